// File: doc/BRIEF.md
# Soft-Decision Branch Metric and Add-Compare-Select Stage

This block is the metric engine of a maximum-likelihood decoder for a rate-1/2 convolutional code with constraint length 7. Each trellis stage it takes one pair of 3-bit soft-quantised channel symbols and converts each symbol to a signed confidence value, where positive means a zero was sent and negative means a one was sent. From these it forms the four signed branch metrics and updates 64 path metrics through 32 two-state add-compare-select butterflies. At each state it keeps the larger sum.

Every accepted stage produces a 64-bit vector of survivor decisions, one bit per next state, with a valid strobe one clock later. A downstream survivor memory and traceback consume this vector. A frame-start input re-seeds the metrics so that decoding begins from state 0. The first symbol of a frame may arrive in the same cycle as the frame-start input. Path metrics are held in 10-bit signed registers. A common offset is removed from all of them whenever state 0 climbs past a threshold, so streams of any length can be decoded.

Top module: `softacs_k7`

## Requirements
- R1: Each 3-bit symbol code c maps to the confidence value 3 - c: code 0 gives +3, code 3 gives 0, code 4 gives -1 and code 7 gives -4.
- R2: With confidences h (from `sym_hi`) and l (from `sym_lo`), the branch metric for expected pair {e1,e0} is (e1 ? -h : h) + (e0 ? -l : l). For example, h = -1 and l = +3 give 2, -4, 4 and -2 for pairs 00, 01, 10 and 11.
- R3: Next state n has predecessors 2*(n mod 32) (upper) and 2*(n mod 32)+1 (lower), with input bit n[5]. Form the 7-bit word {n[5], predecessor}. The expected pair on that branch is e1 = XOR of the word masked by 1111001 and e0 = XOR of the word masked by 1011011, where mask bit i selects word bit i.
- R4: Each next state takes the larger of its two candidate sums. Decision bit n is 1 only when the lower predecessor's sum is strictly larger. A tie gives 0.
- R5: `frame_start` seeds state 0 to 0 and every other state to -256. If `sym_valid` is high in the same cycle, that symbol is processed from the seeded metrics. Otherwise no decision is produced.
- R6: `decision_valid` is high exactly in the cycle after a cycle with `sym_valid` high, and `decision` then carries that stage's vector.
- R7: Over streams of any length, the decisions equal those of an unbounded-integer reference, and the state-0 metric never exceeds +128 after an update.
- R8: While `sym_valid` is low, the path metrics and `decision` are left unchanged.
- R9: Reset clears `decision` and `decision_valid` and leaves the metrics in the frame-start seed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Re-seed path metrics for a new frame |
| sym_valid | input | 1 | A symbol pair is present this cycle |
| sym_hi | input | 3 | Soft code of the first coded bit |
| sym_lo | input | 3 | Soft code of the second coded bit |
| decision | output | 64 | Survivor decision per next state |
| decision_valid | output | 1 | `decision` holds a new stage |

## Verification
The assertions take for granted that symbols arrive from the code's own 3-bit alphabet. That keeps every branch metric within plus or minus 8, and the bound on the state-0 metric relies on that range. They also assume `frame_start` and `sym_valid` are never unknown after reset. The stimulus drives only codes 0 to 7 and always drives both control inputs to defined levels at the falling edge. It mixes clean encoder output, noisy and flipped symbols, all-erasure symbols that force ties, idle gaps, and frame restarts with and without a coincident symbol.

// File: rtl/softacs_k7.sv
module softacs_k7 #(
  parameter int SW = 3,
  parameter int PMW = 10,
  parameter int CL = 7,
  parameter logic [CL-1:0] TAP_HI = 7'b1111001,
  parameter logic [CL-1:0] TAP_LO = 7'b1011011,
  localparam int NS = 1 << (CL - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          sym_valid,
  input  logic [SW-1:0] sym_hi,
  input  logic [SW-1:0] sym_lo,
  output logic [NS-1:0] decision,
  output logic          decision_valid
);

  localparam int HALF = NS / 2;
  localparam int BW = SW + 2;
  localparam int MAXC = (1 << (SW - 1)) - 1;
  localparam logic signed [PMW-1:0] THR = PMW'(1 << (PMW - 3));
  localparam logic signed [PMW-1:0] OFS = THR;
  localparam logic signed [PMW-1:0] PM_LOW = PMW'(-(1 << (PMW - 2)));

  function automatic logic [1:0] exp_pair(input int u, input int p);
    logic [CL-1:0] w;
    w = CL'((u << (CL - 1)) | p);
    return {^(w & TAP_HI), ^(w & TAP_LO)};
  endfunction

  logic signed [BW-1:0]  cf_hi, cf_lo;
  logic signed [BW-1:0]  bm   [4];
  logic signed [PMW-1:0] pm_q [NS];
  logic signed [PMW-1:0] base [NS];
  logic signed [PMW-1:0] acs  [NS];
  logic signed [PMW-1:0] nxt  [NS];
  logic signed [PMW-1:0] seed [NS];
  logic [NS-1:0]         dec;
  logic                  norm;

  assign cf_hi = $signed(BW'(MAXC)) - $signed(BW'(sym_hi));
  assign cf_lo = $signed(BW'(MAXC)) - $signed(BW'(sym_lo));

  assign bm[0] = cf_hi + cf_lo;
  assign bm[1] = cf_hi - cf_lo;
  assign bm[2] = cf_lo - cf_hi;
  assign bm[3] = -cf_hi - cf_lo;

  for (genvar n = 0; n < NS; n++) begin : g_acs
    localparam int J = n % HALF;
    localparam int U = n / HALF;
    localparam logic [1:0] E_UP = exp_pair(U, 2 * J);
    localparam logic [1:0] E_DN = exp_pair(U, 2 * J + 1);
    logic signed [PMW-1:0] s_up, s_dn;

    assign seed[n] = (n == 0) ? '0 : PM_LOW;
    assign base[n] = frame_start ? seed[n] : pm_q[n];
    assign s_up    = base[2*J]     + PMW'(bm[E_UP]);
    assign s_dn    = base[2*J + 1] + PMW'(bm[E_DN]);
    assign dec[n]  = s_dn > s_up;
    assign acs[n]  = dec[n] ? s_dn : s_up;
    assign nxt[n]  = norm ? acs[n] - OFS : acs[n];
  end

  assign norm = acs[0] > THR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) pm_q[i] <= (i == 0) ? '0 : PM_LOW;
      decision       <= '0;
      decision_valid <= 1'b0;
    end else begin
      decision_valid <= sym_valid;
      if (sym_valid) begin
        pm_q     <= nxt;
        decision <= dec;
      end else if (frame_start) begin
        pm_q <= seed;
      end
    end
  end

endmodule

// File: rtl/softacs_k7_chk.sv
module softacs_k7_chk #(
  parameter int NS = 64,
  parameter int PMW = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_start,
  input logic                  sym_valid,
  input logic [NS-1:0]         decision,
  input logic                  decision_valid,
  input logic signed [PMW-1:0] pm0
);

  localparam logic signed [PMW-1:0] THR = PMW'(1 << (PMW - 3));

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> decision_valid);  // R6
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> !decision_valid);  // R6
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable(decision));  // R8
  AST_FRAME_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !sym_valid |=> pm0 == '0);  // R5
  AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && sym_valid |=> !decision[0] && !decision[NS/2]);  // R5
  AST_NORM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pm0 <= THR);  // R7

endmodule

bind softacs_k7 softacs_k7_chk #(.NS(NS), .PMW(PMW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .frame_start(frame_start),
  .sym_valid(sym_valid),
  .decision(decision),
  .decision_valid(decision_valid),
  .pm0(pm_q[0])
);

// File: tb/softacs_k7_tb.sv
`timescale 1ns/1ps
module softacs_k7_tb;
  localparam int NS = 64;

  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, sym_valid = 1'b0;
  logic [2:0] sym_hi = '0, sym_lo = '0;
  logic [NS-1:0] decision;
  logic decision_valid;

  int n_chk = 0, n_bad = 0;
  longint pm [NS];
  logic [NS-1:0] exp_dec = '0;
  logic [5:0] enc_st = '0;

  always #2 clk = ~clk;

  softacs_k7 u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sym_valid(sym_valid),
    .sym_hi(sym_hi), .sym_lo(sym_lo), .decision(decision), .decision_valid(decision_valid)
  );

  function automatic logic [1:0] pair(int u, int p);
    logic [6:0] w;
    w = 7'((u << 6) | p);
    return {^(w & 7'b1111001), ^(w & 7'b1011011)};
  endfunction

  function automatic int conf(logic [2:0] c);
    return 3 - int'(c);
  endfunction

  function automatic int bmv(logic [1:0] e, int h, int l);
    return (e[1] ? -h : h) + (e[0] ? -l : l);
  endfunction

  task automatic model_init();
    for (int i = 0; i < NS; i++) pm[i] = (i == 0) ? 0 : -256;
  endtask

  task automatic model_step(logic [2:0] h, logic [2:0] l);
    longint nx [NS];
    int hv, lv;
    hv = conf(h);
    lv = conf(l);
    for (int n = 0; n < NS; n++) begin
      int j, u;
      longint a, b;
      j = n % 32;
      u = n / 32;
      a = pm[2*j] + bmv(pair(u, 2*j), hv, lv);
      b = pm[2*j+1] + bmv(pair(u, 2*j+1), hv, lv);
      exp_dec[n] = b > a;
      nx[n] = (b > a) ? b : a;
    end
    pm = nx;
  endtask

  task automatic chk_vec(string req, logic [NS-1:0] act, logic [NS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s decision actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s decision_valid actual=%b expected=%b", req, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle and checks at the next falling edge
  task automatic step(bit fs, bit v, logic [2:0] h, logic [2:0] l, string req);
    frame_start = fs;
    sym_valid = v;
    sym_hi = h;
    sym_lo = l;
    if (fs) model_init();
    if (v) model_step(h, l);
    @(negedge clk);
    frame_start = 1'b0;
    sym_valid = 1'b0;
    chk_bit(req, decision_valid, v);
    chk_vec(req, decision, exp_dec);
  endtask

  task automatic enc(bit u, output logic [2:0] h, output logic [2:0] l);
    logic [1:0] c;
    c = pair(int'(u), int'(enc_st));
    enc_st = {u, enc_st[5:1]};
    h = c[1] ? 3'b111 : 3'b000;
    l = c[0] ? 3'b111 : 3'b000;
  endtask

  task automatic t_reset();
    chk_vec("R9", decision, '0);
    chk_bit("R9", decision_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    model_init();
    step(0, 1, 3'b100, 3'b000, "R9");
    step(0, 1, 3'b010, 3'b110, "R9");
  endtask

  task automatic t_example();
    logic [2:0] h, l;
    enc_st = '0;
    step(1, 1, 3'b000, 3'b000, "R5");
    for (int i = 0; i < 8; i++) begin
      enc(i[0], h, l);
      step(0, 1, h, l, "R3");
    end
    step(0, 1, 3'b100, 3'b000, "R2");
    step(0, 1, 3'b000, 3'b100, "R2");
    step(0, 1, 3'b011, 3'b100, "R1");
  endtask

  task automatic t_clean();
    logic [2:0] h, l;
    step(1, 0, 3'b000, 3'b000, "R5");
    enc_st = '0;
    for (int i = 0; i < 60; i++) begin
      enc(1'($urandom_range(0, 1)), h, l);
      step(0, 1, h, l, "R3");
    end
  endtask

  task automatic t_noisy();
    logic [2:0] h, l;
    step(1, 0, 3'b000, 3'b000, "R5");
    enc_st = '0;
    for (int i = 0; i < 80; i++) begin
      enc(1'($urandom_range(0, 1)), h, l);
      h = {h[2] ^ ($urandom_range(0, 5) == 0), 2'($urandom_range(0, 3))};
      l = 3'($urandom_range(0, 7));
      step(0, 1, h, l, "R4");
    end
  endtask

  task automatic t_ties();
    step(1, 1, 3'b011, 3'b011, "R4");
    for (int i = 0; i < 12; i++) step(0, 1, 3'b011, 3'b011, "R4");
    chk_vec("R4 tie", decision, '0);
  endtask

  task automatic t_gaps();
    logic [2:0] h, l;
    for (int i = 0; i < 30; i++) begin
      enc(1'($urandom_range(0, 1)), h, l);
      step(0, 1, h, l ^ 3'($urandom_range(0, 3)), "R6");
      for (int k = 0; k < int'($urandom_range(0, 3)); k++)
        step(0, 0, 3'($urandom), 3'($urandom), "R8");
    end
  endtask

  task automatic t_restart();
    step(0, 1, 3'b101, 3'b001, "R5");
    step(1, 0, 3'b111, 3'b111, "R5");
    step(0, 1, 3'b110, 3'b111, "R5");
    step(0, 1, 3'b001, 3'b000, "R5");
    step(1, 1, 3'b111, 3'b111, "R5");
    step(0, 1, 3'b000, 3'b111, "R5");
  endtask

  task automatic t_long();
    logic [2:0] h, l;
    step(1, 0, 3'b000, 3'b000, "R7");
    enc_st = '0;
    for (int i = 0; i < 3000; i++) begin
      enc(1'($urandom_range(0, 1)), h, l);
      if ($urandom_range(0, 9) == 0) l = ~l;
      step(0, 1, h, l, "R7");
    end
  endtask

  initial begin
    void'($urandom(17));
    repeat (3) @(negedge clk);
    t_reset();
    t_example();
    t_clean();
    t_noisy();
    t_ties();
    t_gaps();
    t_restart();
    t_long();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule